// File: doc/BRIEF.md
# Serial Synthesizer Programming Register

This block takes 20-bit control words from a three-wire serial bus and turns them into the settings a frequency synthesizer needs. The three wires are a serial clock, a data line and a strobe. The serial lines are assumed to be already synchronized to the system clock `clk`. Each rising edge of the serial clock samples one data bit into a staging shift register, but only while the strobe is low. A rising edge of the strobe then commits the staged word to the holding register, and only if exactly 20 bits arrived since the strobe last fell. A word of any other length is dropped and the previous settings stay in force.

The committed word supplies the following settings:
- a power-down request and its kind;
- the reference divider value and its post-scaler bypass bit;
- the main divider value and its post-scaler bypass bit;
- a four-bit field for the second-LO divider.

The power-down code with the enable bit clear and the type bit set has no defined meaning. It is decoded as normal operation and raises a separate error flag.

Top module: `ser_prog_reg`

## Requirements
- R1: After reset the held settings are: no power-down, error flag clear, reference bypass 0, reference divider 4, main bypass 1, main divider 71, LO field 0.
- R2: Bit order in the word, first received to last: power-down enable, power-down type, reference bypass, 5-bit reference divider (MSB first), main bypass, 7-bit main divider (MSB first), 4-bit LO field (MSB first). Taken as a 20-bit number with the first bit as bit 19, the fields sit at bits 19, 18, 17, 16:12, 11, 10:4 and 3:0.
- R3: The outputs change only on a strobe rising edge that follows exactly 20 shifted bits. Words of 19 or 21 bits leave every output unchanged.
- R4: Rising serial-clock edges while the strobe is high shift nothing and do not affect the outputs.
- R5: Power-down decode for (enable, type): (1,1) gives full power-down only, (1,0) gives partial power-down only, and (0,0) gives neither.
- R6: The code (enable, type) = (0,1) drives both power-down outputs low and sets the error flag. The flag clears when a later valid word carries any other code.
- R7: Reset discards a partly shifted word. Bits that arrived before reset do not count towards the 20.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial bit clock, synchronized |
| ser_data | input | 1 | Serial data, synchronized |
| ser_strobe | input | 1 | Strobe: low while shifting, rising edge commits the word |
| pd_full | output | 1 | Full power-down requested |
| pd_partial | output | 1 | Partial power-down, synthesizer kept running |
| pd_undef_err | output | 1 | Undefined power-down code in the held word |
| ref_post_bypass | output | 1 | 1 = reference post-scaler divides by 1 |
| ref_div | output | 5 | Reference divider value |
| main_post_bypass | output | 1 | 1 = main post-scaler divides by 1 |
| main_div | output | 7 | Main divider value |
| lo_div | output | 4 | Second-LO divider field |

## Verification
A wrong bit count or a mis-detected edge shows up at the ports at the first strobe rising edge that follows. Either a well-formed word fails to load, or a malformed one changes the outputs, one system clock after that edge. A mis-wired field position shows up as soon as a word is committed that carries distinct values in neighbouring fields. The sweep therefore varies every field independently, so that a swapped or shifted slice changes at least one committed output. Power-down decode errors, including the undefined code, are visible on the three power-down outputs in the same cycle as the commit.

// File: rtl/ser_prog_pkg.sv
package ser_prog_pkg;
  localparam int unsigned PD_W = 2;
  localparam int unsigned R_W  = 5;
  localparam int unsigned N_W  = 7;
  localparam int unsigned L_W  = 4;
  localparam int unsigned WORD_W = PD_W + 1 + R_W + 1 + N_W + L_W;

  // bit positions, counted from the last bit received (LSB)
  localparam int unsigned L_LSB   = 0;
  localparam int unsigned N_LSB   = L_LSB + L_W;
  localparam int unsigned N7_POS  = N_LSB + N_W;
  localparam int unsigned R_LSB   = N7_POS + 1;
  localparam int unsigned R5_POS  = R_LSB + R_W;
  localparam int unsigned PDT_POS = R5_POS + 1;
  localparam int unsigned PDE_POS = PDT_POS + 1;

  typedef struct packed {
    logic           pd_en;
    logic           pd_type;
    logic           r_byp;
    logic [R_W-1:0] r_val;
    logic           n_byp;
    logic [N_W-1:0] n_val;
    logic [L_W-1:0] l_val;
  } cfg_t;

  function automatic cfg_t unpack_word(input logic [WORD_W-1:0] w);
    cfg_t c;
    c.pd_en   = w[PDE_POS];
    c.pd_type = w[PDT_POS];
    c.r_byp   = w[R5_POS];
    c.r_val   = w[R_LSB +: R_W];
    c.n_byp   = w[N7_POS];
    c.n_val   = w[N_LSB +: N_W];
    c.l_val   = w[L_LSB +: L_W];
    return c;
  endfunction

  // (enable,type) -> {full, partial, undefined}
  function automatic logic [2:0] pd_decode(input logic en, input logic typ);
    return {en & typ, en & ~typ, ~en & typ};
  endfunction
endpackage

// File: rtl/spr_edge_shift.sv
module spr_edge_shift
  import ser_prog_pkg::*;
#(
  parameter int unsigned W     = WORD_W,
  localparam int unsigned CNT_W = $clog2(W + 2)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ser_clk,
  input  logic             ser_data,
  input  logic             ser_strobe,
  output logic [W-1:0]     shreg,
  output logic [CNT_W-1:0] bit_cnt,
  output logic             shift_evt,
  output logic             strobe_rise
);
  localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(W + 1);

  logic sclk_q, stb_q, strobe_fall;

  assign shift_evt   = ser_clk & ~sclk_q & ~ser_strobe;
  assign strobe_rise = ser_strobe & ~stb_q;
  assign strobe_fall = ~ser_strobe & stb_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q  <= 1'b1;
      stb_q   <= 1'b1;
      shreg   <= '0;
      bit_cnt <= '0;
    end else begin
      sclk_q <= ser_clk;
      stb_q  <= ser_strobe;
      if (shift_evt) shreg <= {shreg[W-2:0], ser_data};
      if (strobe_fall)
        bit_cnt <= '0;
      else if (shift_evt && bit_cnt != CNT_SAT)
        bit_cnt <= bit_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/spr_cfg_hold.sv
module spr_cfg_hold
  import ser_prog_pkg::*;
#(
  parameter cfg_t RST_CFG = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_evt,
  input  logic [WORD_W-1:0] word,
  output cfg_t              cfg
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cfg <= RST_CFG;
    else if (load_evt) cfg <= unpack_word(word);
  end
endmodule

// File: rtl/ser_prog_reg.sv
module ser_prog_reg
  import ser_prog_pkg::*;
#(
  parameter logic           DEF_R_BYP = 1'b0,
  parameter logic [R_W-1:0] DEF_R_VAL = R_W'(4),
  parameter logic           DEF_N_BYP = 1'b1,
  parameter logic [N_W-1:0] DEF_N_VAL = N_W'(71),
  parameter logic [L_W-1:0] DEF_L_VAL = '0
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ser_clk,
  input  logic           ser_data,
  input  logic           ser_strobe,
  output logic           pd_full,
  output logic           pd_partial,
  output logic           pd_undef_err,
  output logic           ref_post_bypass,
  output logic [R_W-1:0] ref_div,
  output logic           main_post_bypass,
  output logic [N_W-1:0] main_div,
  output logic [L_W-1:0] lo_div
);
  localparam int unsigned CNT_W = $clog2(WORD_W + 2);
  localparam cfg_t RST_CFG = '{pd_en: 1'b0, pd_type: 1'b0, r_byp: DEF_R_BYP,
                               r_val: DEF_R_VAL, n_byp: DEF_N_BYP,
                               n_val: DEF_N_VAL, l_val: DEF_L_VAL};

  logic [WORD_W-1:0] shreg;
  logic [CNT_W-1:0]  bit_cnt;
  logic              shift_evt, strobe_rise, load_evt;
  cfg_t              cfg;

  spr_edge_shift #(.W(WORD_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
    .ser_strobe(ser_strobe), .shreg(shreg), .bit_cnt(bit_cnt),
    .shift_evt(shift_evt), .strobe_rise(strobe_rise)
  );

  assign load_evt = strobe_rise && (bit_cnt == CNT_W'(WORD_W));

  spr_cfg_hold #(.RST_CFG(RST_CFG)) u_hold (
    .clk(clk), .rst_n(rst_n), .load_evt(load_evt), .word(shreg), .cfg(cfg)
  );

  assign {pd_full, pd_partial, pd_undef_err} = pd_decode(cfg.pd_en, cfg.pd_type);
  assign ref_post_bypass  = cfg.r_byp;
  assign ref_div          = cfg.r_val;
  assign main_post_bypass = cfg.n_byp;
  assign main_div         = cfg.n_val;
  assign lo_div           = cfg.l_val;
endmodule

// File: rtl/spr_checker.sv
module spr_checker
  import ser_prog_pkg::*;
#(
  parameter int unsigned CNT_W = $clog2(WORD_W + 2)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ser_strobe,
  input logic [CNT_W-1:0] bit_cnt,
  input logic             load_evt,
  input logic             pd_full,
  input logic             pd_partial,
  input logic             pd_undef_err,
  input logic             ref_post_bypass,
  input logic [R_W-1:0]   ref_div,
  input logic             main_post_bypass,
  input logic [N_W-1:0]   main_div,
  input logic [L_W-1:0]   lo_div
);
  logic [WORD_W+2:0] outs;
  assign outs = {pd_full, pd_partial, pd_undef_err, ref_post_bypass, ref_div,
                 main_post_bypass, main_div, lo_div};

  // R3
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load_evt |=> $stable(outs));

  // R3
  bad_length_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ser_strobe) && bit_cnt != CNT_W'(WORD_W)) |=> $stable(outs));

  // R4
  strobe_high_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ser_strobe |=> $stable(bit_cnt));

  // R3
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= CNT_W'(WORD_W + 1));

  // R5
  pd_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({pd_full, pd_partial, pd_undef_err}) <= 1);

  // R6
  undef_no_pd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pd_undef_err |-> !(pd_full || pd_partial));
endmodule

bind ser_prog_reg spr_checker u_chk (
  .clk(clk), .rst_n(rst_n), .ser_strobe(ser_strobe), .bit_cnt(bit_cnt),
  .load_evt(load_evt), .pd_full(pd_full), .pd_partial(pd_partial),
  .pd_undef_err(pd_undef_err), .ref_post_bypass(ref_post_bypass),
  .ref_div(ref_div), .main_post_bypass(main_post_bypass),
  .main_div(main_div), .lo_div(lo_div)
);

// File: tb/ser_prog_reg_bench.sv
module ser_prog_reg_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_clk = 1'b0, ser_data = 1'b0, ser_strobe = 1'b1;
  logic pd_full, pd_partial, pd_undef_err, ref_post_bypass, main_post_bypass;
  logic [4:0] ref_div;
  logic [6:0] main_div;
  logic [3:0] lo_div;

  int checks = 0, errors = 0, cycles = 0;
  int exp_word;
  bit done = 0;

  always #2 clk = ~clk;

  ser_prog_reg u_ser_prog_reg (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
    .ser_strobe(ser_strobe), .pd_full(pd_full), .pd_partial(pd_partial),
    .pd_undef_err(pd_undef_err), .ref_post_bypass(ref_post_bypass),
    .ref_div(ref_div), .main_post_bypass(main_post_bypass),
    .main_div(main_div), .lo_div(lo_div)
  );

  function automatic int make_word(int pe, int pt, int rb, int rv, int nb, int nv, int lv);
    return pe * 524288 + pt * 262144 + rb * 131072 + rv * 4096 + nb * 2048 + nv * 16 + lv;
  endfunction

  function automatic int fld(int w, int lsb_weight, int span);
    return (w / lsb_weight) % span;
  endfunction

  task automatic wait_cyc(int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic check(string req);
    int pe, pt;
    logic [21:0] act, exp;
    pe = fld(exp_word, 524288, 2);
    pt = fld(exp_word, 262144, 2);
    exp = {1'(pe == 1 && pt == 1), 1'(pe == 1 && pt == 0), 1'(pe == 0 && pt == 1),
           1'(fld(exp_word, 131072, 2)), 5'(fld(exp_word, 4096, 32)),
           1'(fld(exp_word, 2048, 2)), 7'(fld(exp_word, 16, 128)),
           4'(fld(exp_word, 1, 16))};
    act = {pd_full, pd_partial, pd_undef_err, ref_post_bypass, ref_div,
           main_post_bypass, main_div, lo_div};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic shift_bits(int w, int len);
    for (int b = len - 1; b >= 0; b--) begin
      ser_data = 1'((w >> b) & 1);
      ser_clk = 1'b0; wait_cyc(2);
      ser_clk = 1'b1; wait_cyc(2);
    end
  endtask

  task automatic send(int w, int len);
    ser_strobe = 1'b0; wait_cyc(2);
    shift_bits(w, len);
    ser_strobe = 1'b1; wait_cyc(3);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; wait_cyc(3);
    rst_n = 1'b1; wait_cyc(1);
  endtask

  initial begin
    @(negedge clk);
    while (!done) begin
      @(negedge clk);
      cycles++;
      if (cycles > 150000) begin
        errors++;
        $display("FAIL watchdog actual=%0d expected=<150000", cycles);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    int w;
    wait_cyc(3);
    rst_n = 1'b1; wait_cyc(1);
    exp_word = make_word(0, 0, 0, 4, 1, 71, 0);
    check("R1 defaults");

    // R2 sweep: each field varied independently
    for (int i = 0; i < 128; i++) begin
      w = make_word((i / 2) % 2, i % 2, (i / 4) % 2, (i * 7) % 32, (i / 3) % 2, i, (i * 5) % 16);
      send(w, 20);
      exp_word = w;
      check("R2 field sweep");
    end

    // R5 power-down codes
    w = make_word(1, 1, 1, 9, 0, 100, 3); send(w, 20); exp_word = w; check("R5 full");
    w = make_word(1, 0, 0, 31, 1, 64, 15); send(w, 20); exp_word = w; check("R5 partial");
    w = make_word(0, 0, 1, 4, 0, 127, 8); send(w, 20); exp_word = w; check("R5 normal");
    // R6 undefined code then clear
    w = make_word(0, 1, 0, 17, 1, 85, 10); send(w, 20); exp_word = w; check("R6 undef");
    w = make_word(1, 0, 1, 6, 1, 90, 1); send(w, 20); exp_word = w; check("R6 cleared");

    // R3 wrong lengths discarded
    send(make_word(1, 1, 0, 0, 0, 0, 0), 19); check("R3 19 bits");
    send(make_word(0, 0, 0, 0, 0, 0, 0), 21); check("R3 21 bits");
    send(0, 0);                               check("R3 empty");
    w = make_word(0, 0, 0, 12, 0, 70, 6); send(w, 20); exp_word = w; check("R3 valid after bad");

    // R4 serial clocks while strobe high
    ser_strobe = 1'b1;
    shift_bits(32'hFFFFF, 25);
    wait_cyc(3);
    check("R4 strobe high");
    w = make_word(1, 1, 1, 21, 0, 66, 13); send(w, 20); exp_word = w; check("R4 next word");

    // R7 reset mid-word, then a full word counts from zero
    ser_strobe = 1'b0; wait_cyc(2);
    shift_bits(32'h3FF, 10);
    do_reset();
    exp_word = make_word(0, 0, 0, 4, 1, 71, 0);
    check("R1 after reset");
    w = make_word(1, 0, 1, 27, 0, 99, 5);
    shift_bits(w, 20);
    ser_strobe = 1'b1; wait_cyc(3);
    exp_word = w;
    check("R7 partial word discarded by reset");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule